// File: doc/BRIEF.md
# Register Write-Protection Key Gate

This block stands in front of a bank of protected registers (time, date, control, prescaler, alarm and the status/flags register) and decides whether their write strobes may pass. A single byte-wide key register sits on a simple register bus at one address. The bank opens only after two fixed key bytes have been written to that register one after the other. Any other byte written there closes the bank again at once.

A separate backup-domain enable input must also be high. While it is low, protected strobes are blocked and writes to the key register are ignored. The gate drives one qualified strobe per protected register and a status bit that shows whether the bank is unlocked. The key register itself always reads back as zero, so the lock state is visible only on the status output.

Top module: `wpk_guard`

## Requirements
- R1: A synchronous active-high reset puts the gate in the locked state. After reset, `unlocked` is 0 and all qualified strobes are 0.
- R2: In the locked state, a key-register write of 0xCA arms the gate. A following key-register write of 0x53 opens it. `unlocked` reads 1 from the cycle after the second write.
- R3: When armed, any key-register write other than 0x53 returns the gate to the locked state. This includes a repeated 0xCA. A fresh 0xCA is then needed to arm it again.
- R4: When unlocked, any key-register write relocks the gate in the next cycle, whatever its value (for example 0xFF, 0xCA or 0x53).
- R5: In the locked state, a key-register write of any byte other than 0xCA leaves the gate locked. A lone 0x53 never unlocks it.
- R6: Each qualified strobe `prot_wr_en[i]` equals `prot_wr_req[i]` in the same cycle while the gate is unlocked and `bkp_en` is 1. Otherwise it is 0, so locked writes are dropped.
- R7: While `bkp_en` is 0, key-register writes are ignored and the lock state is held, whether it is locked, armed or unlocked.
- R8: Bus writes to any address other than the key address neither advance nor reset the key sequence.
- R9: `key_rdata` is always zero, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 8 | Register bus write byte |
| key_rdata | output | 8 | Read data of the key register (always zero) |
| bkp_en | input | 1 | Backup-domain write enable |
| prot_wr_req | input | NPROT | Raw write strobes for the protected registers |
| prot_wr_en | output | NPROT | Qualified write strobes |
| unlocked | output | 1 | High while the protected bank is open |

## Verification
The assertions assume that the bus is synchronous to `clk`, that `bus_wr` is a one-cycle strobe with the address and byte valid in that cycle, and that `bkp_en` and `prot_wr_req` are stable around the clock edge. The stimulus drives all inputs at the falling edge, so every value is settled well before the rising edge. It issues at most one bus write per cycle. Reset is held for several cycles before any check is made, so no property sees an uninitialised state.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    localparam logic [7:0] WPK_KEY_FIRST_DEF  = 8'hCA;
    localparam logic [7:0] WPK_KEY_SECOND_DEF = 8'h53;

    typedef enum logic [1:0] {
        WP_LOCKED = 2'd0,
        WP_ARMED  = 2'd1,
        WP_OPEN   = 2'd2
    } wp_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] value;
    } key_cmd_t;

    function automatic wp_state_e wp_next(
        input wp_state_e  cur,
        input key_cmd_t   cmd,
        input logic [7:0] k_first,
        input logic [7:0] k_second
    );
        wp_state_e nxt;
        nxt = cur;
        if (cmd.valid) begin
            unique case (cur)
                WP_LOCKED: nxt = (cmd.value == k_first)  ? WP_ARMED : WP_LOCKED;
                WP_ARMED:  nxt = (cmd.value == k_second) ? WP_OPEN  : WP_LOCKED;
                WP_OPEN:   nxt = WP_LOCKED;
                default:   nxt = WP_LOCKED;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wpk_key_port.sv
module wpk_key_port
    import wpk_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bkp_en,
    output key_cmd_t          cmd,
    output logic [7:0]        rdata
);
    logic hit;

    assign hit       = (bus_addr == KEY_ADDR);
    assign cmd.valid = bus_wr & hit & bkp_en;
    assign cmd.value = bus_wdata;
    assign rdata     = '0;

endmodule

// File: rtl/wpk_lock_fsm.sv
module wpk_lock_fsm
    import wpk_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = WPK_KEY_FIRST_DEF,
    parameter logic [7:0] KEY_SECOND = WPK_KEY_SECOND_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bkp_en,
    input  key_cmd_t cmd,
    output logic     open_o
);
    wp_state_e state_q;
    wp_state_e state_d;

    always_comb state_d = wp_next(state_q, cmd, KEY_FIRST, KEY_SECOND);

    always_ff @(posedge clk) begin
        if (rst) state_q <= WP_LOCKED;
        else     state_q <= state_d;
    end

    assign open_o = (state_q == WP_OPEN);

    AST_RESET_LOCKED: assert property (@(posedge clk) rst |=> !open_o); // R1
    AST_OPEN_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(cmd.valid && cmd.value == KEY_SECOND)); // R2
    AST_ARMED_WRONG: assert property (@(posedge clk) disable iff (rst)
        (state_q == WP_ARMED && cmd.valid && cmd.value != KEY_SECOND) |=> state_q == WP_LOCKED); // R3
    AST_OPEN_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (open_o && cmd.valid) |=> !open_o); // R4
    AST_BKP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bkp_en |=> $stable(state_q)); // R7

endmodule

// File: rtl/wpk_strobe_gate.sv
module wpk_strobe_gate #(
    parameter int NPROT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             bkp_en,
    input  logic [NPROT-1:0] req,
    output logic [NPROT-1:0] en
);
    logic pass;

    assign pass = open_i & bkp_en;

    for (genvar i = 0; i < NPROT; i++) begin : g_lane
        assign en[i] = req[i] & pass;
    end

    AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (rst)
        !open_i |-> en == '0); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (en & ~req) == '0); // R6

endmodule

// File: rtl/wpk_guard.sv
module wpk_guard
    import wpk_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h24,
    parameter int                NPROT      = 6,
    parameter logic [7:0]        KEY_FIRST  = WPK_KEY_FIRST_DEF,
    parameter logic [7:0]        KEY_SECOND = WPK_KEY_SECOND_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        key_rdata,
    input  logic              bkp_en,
    input  logic [NPROT-1:0]  prot_wr_req,
    output logic [NPROT-1:0]  prot_wr_en,
    output logic              unlocked
);
    key_cmd_t cmd;
    logic     open_s;

    wpk_key_port #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_port (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bkp_en    (bkp_en),
        .cmd       (cmd),
        .rdata     (key_rdata)
    );

    wpk_lock_fsm #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .bkp_en (bkp_en),
        .cmd    (cmd),
        .open_o (open_s)
    );

    wpk_strobe_gate #(.NPROT(NPROT)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .open_i (open_s),
        .bkp_en (bkp_en),
        .req    (prot_wr_req),
        .en     (prot_wr_en)
    );

    assign unlocked = open_s;

    AST_OTHER_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != KEY_ADDR) |=> $stable(unlocked)); // R8
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        key_rdata == 8'h00); // R9

endmodule

// File: tb/wpk_guard_tb.sv
`timescale 1ns/1ps
module wpk_guard_tb;
    localparam int NPROT = 6;
    localparam logic [7:0] KADDR = 8'h24;

    logic             clk = 1'b0;
    logic             rst;
    logic             bus_wr;
    logic [7:0]       bus_addr;
    logic [7:0]       bus_wdata;
    logic [7:0]       key_rdata;
    logic             bkp_en;
    logic [NPROT-1:0] prot_wr_req;
    logic [NPROT-1:0] prot_wr_en;
    logic             unlocked;

    always #2 clk = ~clk;

    wpk_guard u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .key_rdata(key_rdata), .bkp_en(bkp_en),
        .prot_wr_req(prot_wr_req), .prot_wr_en(prot_wr_en), .unlocked(unlocked)
    );

    typedef struct {
        logic             unl;
        logic [NPROT-1:0] en;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   mstate = 0;   // 0 locked, 1 armed, 2 open
    bit   finished = 0;

    task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] data,
                        input logic bkp, input logic [NPROT-1:0] req, input string tag);
        exp_t e;
        @(negedge clk);
        rst = 1'b0; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        bkp_en = bkp; prot_wr_req = req;
        e.unl = (mstate == 2);
        e.en  = (mstate == 2 && bkp) ? req : '0;
        e.tag = tag;
        exp_q.push_back(e);
        if (wr && addr == KADDR && bkp) begin
            case (mstate)
                0: mstate = (data == 8'hCA) ? 1 : 0;
                1: mstate = (data == 8'h53) ? 2 : 0;
                default: mstate = 0;
            endcase
        end
    endtask

    task automatic key(input logic [7:0] d, input string tag);
        step(1'b1, KADDR, d, 1'b1, '0, tag);
    endtask

    task automatic idle(input logic [NPROT-1:0] req, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, req, tag);
    endtask

    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (unlocked !== e.unl) begin
                n_fail++;
                $display("FAIL %s unlocked actual=%b expected=%b", e.tag, unlocked, e.unl);
            end
            n_chk++;
            if (prot_wr_en !== e.en) begin
                n_fail++;
                $display("FAIL %s prot_wr_en actual=%h expected=%h", e.tag, prot_wr_en, e.en);
            end
            n_chk++;
            if (key_rdata !== 8'h00) begin
                n_fail++;
                $display("FAIL R9 key_rdata actual=%h expected=00", key_rdata);
            end
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; bkp_en = 1; prot_wr_req = '0;
        repeat (4) @(negedge clk);
        mstate = 0;
        // R1: reset state
        idle(6'h3F, "R1");
        // R5: wrong first bytes keep the bank locked
        key(8'h53, "R5"); key(8'h53, "R5"); key(8'hFF, "R5"); idle(6'h3F, "R5");
        // R2: ordered unlock, then R6 strobe pass-through
        key(8'hCA, "R2"); key(8'h53, "R2"); idle(6'h2A, "R6"); idle(6'h15, "R6");
        // R4: wrong key relocks
        key(8'hFF, "R4"); idle(6'h3F, "R4");
        // R3: repeated first key does not restart
        key(8'hCA, "R3"); key(8'hCA, "R3"); key(8'h53, "R3"); idle(6'h3F, "R3");
        key(8'hCA, "R3"); key(8'h00, "R3"); idle(6'h01, "R3");
        key(8'hCA, "R3"); key(8'h53, "R3"); idle(6'h01, "R6");
        // R4: first key while open relocks
        key(8'hCA, "R4"); idle(6'h3F, "R4");
        // R4: second key while open relocks
        key(8'hCA, "R2"); key(8'h53, "R2"); key(8'h53, "R4"); idle(6'h3F, "R4");
        // R8: other-address writes do not disturb the sequence
        key(8'hCA, "R8"); step(1'b1, 8'h08, 8'hFF, 1'b1, '0, "R8");
        key(8'h53, "R8"); idle(6'h3F, "R8");
        step(1'b1, 8'h0C, 8'hFF, 1'b1, 6'h3F, "R8"); idle(6'h20, "R8");
        // R7: backup enable low blocks strobes and freezes the state
        step(1'b0, 8'h00, 8'h00, 1'b0, 6'h3F, "R7");
        step(1'b1, KADDR, 8'hFF, 1'b0, 6'h3F, "R7");
        idle(6'h3F, "R7");
        key(8'hFF, "R4"); idle(6'h3F, "R4");
        step(1'b1, KADDR, 8'hCA, 1'b0, '0, "R7");
        step(1'b1, KADDR, 8'h53, 1'b0, '0, "R7");
        idle(6'h3F, "R7");
        key(8'hCA, "R7"); step(1'b1, KADDR, 8'h00, 1'b0, '0, "R7");
        key(8'h53, "R7"); idle(6'h3F, "R7");
        // R1: reset from the open state
        @(negedge clk); rst = 1'b1; mstate = 0;
        @(negedge clk);
        idle(6'h3F, "R1");
        @(negedge clk); @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule